// File: doc/BRIEF.md
# Multi-Lane Integrator Cascade for a Recursive Decimator

This block is the integrator (accumulator) half of a cascaded integrator-comb decimator, rebuilt so that each register runs at a fraction of the sample rate. An upstream commutator packs `LANES` consecutive input samples into one wide word per clock. The block integrates that word through `STAGES` cascaded accumulators. Each clock it returns `LANES` integrated samples in the same lane order. The results match, bit for bit, a single accumulator cascade clocked once per sample.

Each stage is a registered parallel-prefix network followed by one accumulation level. The prefix network doubles its lane stride at every level, so no path between registers has more than one adder. The accumulation level holds the running total of everything seen so far, called the carry. It adds the carry to every prefix lane and then advances the carry by the sum of the whole block. All arithmetic uses the full accumulator width and wraps modulo 2^`ACC_W`, as a recursive decimator needs. A small control module moves a valid flag down the pipeline and hands each register level its load and clear strobes.

Top module: `cic_lane_integrator`

## Requirements
- R1: Lane k of `inData` (bits k*IN_W through k*IN_W+IN_W-1) holds the k-th oldest sample of the block, as a signed two's-complement value that is sign-extended to ACC_W bits. Lane k of `outData` (bits k*ACC_W through k*ACC_W+ACC_W-1) carries the result for that same sample.
- R2: Every output lane equals the output of a STAGES-deep cascade of inclusive accumulators y[n] = y[n-1] + x[n], with each stage feeding the next and every sample of every earlier valid block counted in order.
- R3: `outValid` is high for exactly one cycle per accepted block. It rises exactly STAGES*(log2(LANES)+1) clock edges after the edge that sampled `inValid` high, and the blocks leave in the order they arrived.
- R4: A cycle with `inValid` low is ignored. It changes no accumulator, whatever value `inData` holds, and idle cycles between blocks do not change later results.
- R5: All sums wrap modulo 2^ACC_W, so sustained full-scale positive or negative input gives the wrapped value of the exact cascade.
- R6: A synchronous `rst` clears every accumulator, every pipeline register and `outValid`. `outData` reads zero after reset, and the next stream integrates from zero.
- R7: While `outValid` is low, `outData` keeps its previous value.
- R8: In each stage the carry register always equals that stage's last output lane, so the next block continues from the final sum of the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock, one block of LANES samples per edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Qualifies the block on inData |
| inData | input | LANES*IN_W | Commutated samples, lane 0 oldest |
| outValid | output | 1 | Marks a block of integrated outputs |
| outData | output | LANES*ACC_W | Integrated samples, lane 0 oldest |

## Verification
The bench sends a ramp and single-lane impulses that place one nonzero sample in each lane in turn. An error in the prefix stride or the lane order shows up there as a wrong position rather than a wrong size. Long random streams exercise the carry that passes between blocks. Runs of the largest positive and the most negative code drive the narrow 16-bit bench accumulators through many wraps, which separates true modular arithmetic from saturation or lost sign extension. Bursts with random gaps and junk data on the idle cycles, plus a reset in the middle of a stream, show that bubbles leave no trace, that the latency stays fixed, and that a new stream starts from zero.

// File: rtl/cicpar_pkg.sv
package cicpar_pkg;

  // Strobes handed from control to one register level of the datapath.
  typedef struct packed {
    logic clear;  // synchronous clear of the level
    logic load;   // a valid block enters the level on this edge
  } stepCtrl_t;

  // Number of registered prefix levels needed for a lane count.
  function automatic int prefixLevels(input int lanes);
    return (lanes > 1) ? $clog2(lanes) : 0;
  endfunction

endpackage

// File: rtl/cicpar_ctrl.sv
module cicpar_ctrl
  import cicpar_pkg::*;
#(
  parameter int DEPTH = 9
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      inValid,
  output stepCtrl_t [DEPTH-1:0]     step,
  output logic                      outValid
);

  logic [DEPTH-1:0] validPipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      validPipe <= '0;
    end else begin
      validPipe <= {validPipe[DEPTH-2:0], inValid};
    end
  end

  always_comb begin
    for (int t = 0; t < DEPTH; t++) begin
      step[t].clear = rst;
      step[t].load  = (t == 0) ? inValid : validPipe[(t == 0) ? 0 : t - 1];
    end
  end

  assign outValid = validPipe[DEPTH-1];

  // A block can only leave if one entered the level before the last.
  AST_OUT_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(step[DEPTH-1].load)); // R3

endmodule

// File: rtl/cicpar_level.sv
module cicpar_level
  import cicpar_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int ACC_W  = 28,
  parameter int STRIDE = 1,
  parameter bit ACCUM  = 1'b0
) (
  input  logic                     clk,
  input  stepCtrl_t                ctl,
  input  logic [LANES*ACC_W-1:0]   dIn,
  output logic [LANES*ACC_W-1:0]   dOut
);

  localparam int TOP_LSB = (LANES - 1) * ACC_W;

  generate
    if (ACCUM) begin : g_acc
      // Running total of all earlier blocks of this stage.
      logic [ACC_W-1:0] carry;

      always_ff @(posedge clk) begin
        if (ctl.clear) begin
          carry <= '0;
          dOut  <= '0;
        end else if (ctl.load) begin
          for (int k = 0; k < LANES; k++) begin
            dOut[k*ACC_W +: ACC_W] <= carry + dIn[k*ACC_W +: ACC_W];
          end
          carry <= carry + dIn[TOP_LSB +: ACC_W];
        end
      end

      AST_CARRY_HOLD: assert property (@(posedge clk) disable iff (ctl.clear)
        !ctl.load |=> $stable(carry)); // R4

      AST_CARRY_IS_LAST: assert property (@(posedge clk) disable iff (ctl.clear)
        carry == dOut[TOP_LSB +: ACC_W]); // R8
    end else begin : g_pre
      always_ff @(posedge clk) begin
        if (ctl.clear) begin
          dOut <= '0;
        end else if (ctl.load) begin
          for (int k = 0; k < LANES; k++) begin
            if (k >= STRIDE) begin
              dOut[k*ACC_W +: ACC_W] <= dIn[k*ACC_W +: ACC_W]
                                      + dIn[(k - STRIDE)*ACC_W +: ACC_W];
            end else begin
              dOut[k*ACC_W +: ACC_W] <= dIn[k*ACC_W +: ACC_W];
            end
          end
        end
      end

      AST_LANE0_PASS: assert property (@(posedge clk) disable iff (ctl.clear)
        ctl.load |=> dOut[ACC_W-1:0] == $past(dIn[ACC_W-1:0])); // R2
    end
  endgenerate

  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (ctl.clear)
    !ctl.load |=> $stable(dOut)); // R7

endmodule

// File: rtl/cicpar_datapath.sv
module cicpar_datapath
  import cicpar_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int STAGES = 4,
  parameter int IN_W   = 12,
  parameter int ACC_W  = 28,
  parameter int DEPTH  = STAGES * (prefixLevels(LANES) + 1)
) (
  input  logic                      clk,
  input  stepCtrl_t [DEPTH-1:0]     step,
  input  logic [LANES*IN_W-1:0]     inData,
  output logic [LANES*ACC_W-1:0]    outData
);

  localparam int LOGN = prefixLevels(LANES);
  localparam int SPS  = LOGN + 1;  // register levels per stage
  localparam int BUSW = LANES * ACC_W;

  logic [BUSW-1:0] extIn;
  logic [BUSW-1:0] bus [DEPTH];

  // R1: sign-extend every commutated lane to full width.
  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      extIn[k*ACC_W +: ACC_W] = ACC_W'($signed(inData[k*IN_W +: IN_W]));
    end
  end

  genvar s, l;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      for (l = 0; l <= LOGN; l++) begin : g_level
        localparam int T = s * SPS + l;
        logic [BUSW-1:0] levelIn;
        if (T == 0) begin : g_first
          assign levelIn = extIn;
        end else begin : g_chain
          assign levelIn = bus[(T == 0) ? 0 : T - 1];
        end
        cicpar_level #(
          .LANES (LANES),
          .ACC_W (ACC_W),
          .STRIDE(1 << l),
          .ACCUM (l == LOGN)
        ) u_level (
          .clk (clk),
          .ctl (step[T]),
          .dIn (levelIn),
          .dOut(bus[T])
        );
      end
    end
  endgenerate

  assign outData = bus[DEPTH-1];

endmodule

// File: rtl/cic_lane_integrator.sv
module cic_lane_integrator
  import cicpar_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int STAGES = 4,
  parameter int IN_W   = 12,
  parameter int ACC_W  = 28
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    inValid,
  input  logic [LANES*IN_W-1:0]   inData,
  output logic                    outValid,
  output logic [LANES*ACC_W-1:0]  outData
);

  localparam int LATENCY = STAGES * (prefixLevels(LANES) + 1);

  stepCtrl_t [LATENCY-1:0] step;

  cicpar_ctrl #(
    .DEPTH(LATENCY)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .step    (step),
    .outValid(outValid)
  );

  cicpar_datapath #(
    .LANES (LANES),
    .STAGES(STAGES),
    .IN_W  (IN_W),
    .ACC_W (ACC_W),
    .DEPTH (LATENCY)
  ) u_dp (
    .clk    (clk),
    .step   (step),
    .inData (inData),
    .outData(outData)
  );

  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> $stable(outData)); // R7

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> !outValid); // R6

endmodule

// File: tb/sim_cic_lane_integrator.sv
module sim_cic_lane_integrator;

  localparam int LANES  = 4;
  localparam int STAGES = 3;
  localparam int IN_W   = 8;
  localparam int ACC_W  = 16;
  localparam int LAT    = 9;  // 3 stages * (2 prefix levels + 1)

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [LANES*IN_W-1:0]  inData = '0;
  logic                   outValid;
  logic [LANES*ACC_W-1:0] outData;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string phase = "R6 reset";
  bit done = 1'b0;

  logic [ACC_W-1:0]       refAcc [STAGES];
  logic [LANES*ACC_W-1:0] expQ [$];
  int                     cycQ [$];
  logic [LANES*ACC_W-1:0] lastOut = '0;

  always #4 clk = ~clk;  // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  cic_lane_integrator #(
    .LANES(LANES), .STAGES(STAGES), .IN_W(IN_W), .ACC_W(ACC_W)
  ) u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .outValid(outValid), .outData(outData)
  );

  task automatic check(input bit ok, input string msg,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic refClear();
    for (int s = 0; s < STAGES; s++) refAcc[s] = '0;
  endtask

  task automatic sendBlock(input logic [LANES*IN_W-1:0] blk);
    logic [LANES*ACC_W-1:0] e;
    logic [ACC_W-1:0] v;
    @(negedge clk);
    inData  = blk;
    inValid = 1'b1;
    for (int k = 0; k < LANES; k++) begin
      v = ACC_W'($signed(blk[k*IN_W +: IN_W]));
      for (int s = 0; s < STAGES; s++) begin
        refAcc[s] = refAcc[s] + v;
        v = refAcc[s];
      end
      e[k*ACC_W +: ACC_W] = v;
    end
    expQ.push_back(e);
    cycQ.push_back(cyc);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      inData  = $urandom;
    end
  endtask

  // Output monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (rst) begin
      lastOut = outData;
    end else if (outValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, {"R3 unexpected output ", phase}, 1, 0);
      end else begin
        logic [LANES*ACC_W-1:0] e;
        int c0;
        e  = expQ.pop_front();
        c0 = cycQ.pop_front();
        check(cyc - c0 == LAT, {"R3 latency ", phase}, cyc - c0, LAT);
        for (int k = 0; k < LANES; k++) begin
          check(outData[k*ACC_W +: ACC_W] == e[k*ACC_W +: ACC_W],
                $sformatf("%s lane %0d", phase, k),
                outData[k*ACC_W +: ACC_W], e[k*ACC_W +: ACC_W]);
        end
      end
      lastOut = outData;
    end else begin
      check(outData == lastOut, {"R7 hold ", phase}, outData, lastOut);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    refClear();
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R6 outValid after reset", outValid, 0);
    check(outData == '0, "R6 outData after reset", outData, 0);
    @(negedge clk);
    rst = 1'b0;

    phase = "R2 ramp";
    for (int b = 0; b < 20; b++) begin
      logic [LANES*IN_W-1:0] blk;
      for (int k = 0; k < LANES; k++) blk[k*IN_W +: IN_W] = IN_W'(b * LANES + k);
      sendBlock(blk);
    end
    idle(LAT + 2);

    phase = "R1 impulse lanes";
    for (int k = 0; k < LANES; k++) begin
      logic [LANES*IN_W-1:0] blk;
      blk = '0;
      blk[k*IN_W +: IN_W] = IN_W'(k + 3);
      sendBlock(blk);
      sendBlock('0);
      idle(3);
    end
    idle(LAT + 2);

    phase = "R2 random back-to-back";
    for (int b = 0; b < 300; b++) sendBlock($urandom);
    idle(LAT + 2);

    phase = "R5 full-scale positive";
    for (int b = 0; b < 100; b++) sendBlock({LANES{8'h7F}});
    phase = "R5 full-scale negative";
    for (int b = 0; b < 100; b++) sendBlock({LANES{8'h80}});
    phase = "R5 alternating extremes";
    for (int b = 0; b < 60; b++) sendBlock({8'h80, 8'h7F, 8'h80, 8'h7F});
    idle(LAT + 2);

    phase = "R4 bubbles with junk data";
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(1, 0) == 1) sendBlock($urandom);
      else idle(1);
    end
    idle(LAT + 2);
    check(expQ.size() == 0, "R3 all blocks returned", expQ.size(), 0);

    phase = "R6 mid-stream reset";
    for (int b = 0; b < 5; b++) sendBlock($urandom);
    @(negedge clk);
    inValid = 1'b0;
    rst = 1'b1;
    expQ.delete();
    cycQ.delete();
    refClear();
    @(negedge clk);
    @(negedge clk);
    check(outValid == 1'b0, "R6 outValid cleared", outValid, 0);
    check(outData == '0, "R6 outData cleared", outData, 0);
    rst = 1'b0;
    phase = "R6 restart from zero";
    for (int b = 0; b < 50; b++) sendBlock($urandom);
    idle(LAT + 2);
    check(expQ.size() == 0, "R3 all blocks returned after reset", expQ.size(), 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule